// File: doc/BRIEF.md
# Fractional Baud-Rate Enable Generator

This block derives two periodic one-cycle enables from the system clock. Each enable uses an integer divisor plus a fraction counted in sixteenths of a clock. The first channel paces a serial bit clock. Its period is (count+1)×16 system clocks plus the fraction. The second channel paces an infrared sampling reference. Its period is (count+1) system clocks plus the fraction.

A channel realises its fraction with a phase accumulator. In each period the fraction is added to the accumulator. When the sum carries out, that period is stretched by one extra clock. Over any sixteen consecutive periods the total length is therefore exactly sixteen times the fractional divisor. This keeps the achieved rate well within 1% of the target.

Software programs four write-only registers through a simple write port. Any register write restarts both channels from a clean phase. A zero infrared count is illegal, and it silences that channel.

Top module: `baud_frac_gen`

## Requirements
- R1: Address 0 sets the serial count from wr_data_i[7:0]. With fraction 0, the serial enable repeats every (count+1)×16 clocks.
- R2: Address 1 sets the serial fraction F from wr_data_i[7:4]. Each serial period lasts base or base+1 clocks. Period k after a restart (k from 0) gets the extra clock exactly when ((k×F) mod 16) + F ≥ 16. Any 16 consecutive periods total 16×base + F clocks.
- R3: Address 2 sets the infrared count from wr_data_i[3:0]. With fraction 0, the infrared enable repeats every count+1 clocks.
- R4: Address 3 sets the infrared fraction from wr_data_i[7:4]. It uses the same stretching rule and the same 16-period total as R2, with base = count+1.
- R5: While the infrared count is 0, ir_tick_o stays low.
- R6: Each enable pulse is exactly one clock wide.
- R7: A write to any address restarts both channels with the accumulator at zero. Neither enable pulses in the cycle after the write. The first pulse of each running channel comes in the base-th cycle after the write edge.
- R8: Write data bits outside the addressed field have no effect.
- R9: After reset all registers are zero. The serial enable then repeats every 16 clocks, and the infrared enable is silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (0 serial count, 1 serial fraction, 2 infrared count, 3 infrared fraction) |
| wr_data_i | input | 16 | Write data |
| uart_tick_o | output | 1 | Serial bit-clock enable pulse |
| ir_tick_o | output | 1 | Infrared sample-clock enable pulse |

## Verification
The channels are driven with several settings:
- Fraction 0 isolates the integer divisor and the ×16 prescale.
- A mid-range fraction (5) shows whether the stretched periods fall in accumulator order.
- Fraction 15 on the shortest legal infrared divisor tests back-to-back stretched periods without two adjacent pulses.

Every cycle is compared with a behavioural model, and a 16-period window total confirms the exact average divisor. Three more cases are covered:
- A write in the middle of a period separates a true restart from a stretched period.
- Writes with junk outside the fields expose decode leakage.
- A zero infrared count confirms that the channel is silenced.

// File: rtl/baud_frac_pkg.sv
package baud_frac_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_UART = 0;
  localparam int CH_IR = 1;

  typedef enum logic [1:0] {
    ADDR_UART_CNT  = 2'd0,
    ADDR_UART_FRAC = 2'd1,
    ADDR_IR_CNT    = 2'd2,
    ADDR_IR_FRAC   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_frac_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int UART_CNT_W = 8,
  parameter int IR_CNT_W   = 4,
  parameter int FRAC_W     = 4,
  parameter int FRAC_LSB   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [UART_CNT_W-1:0] uart_cnt_o,
  output logic [IR_CNT_W-1:0]   ir_cnt_o,
  output logic [FRAC_W-1:0]     uart_frac_o,
  output logic [FRAC_W-1:0]     ir_frac_o
);
  logic unused_data;
  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uart_cnt_o  <= '0;
      ir_cnt_o    <= '0;
      uart_frac_o <= '0;
      ir_frac_o   <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        ADDR_UART_CNT:  uart_cnt_o  <= wr_data_i[UART_CNT_W-1:0];
        ADDR_UART_FRAC: uart_frac_o <= wr_data_i[FRAC_LSB +: FRAC_W];
        ADDR_IR_CNT:    ir_cnt_o    <= wr_data_i[IR_CNT_W-1:0];
        default:        ir_frac_o   <= wr_data_i[FRAC_LSB +: FRAC_W];
      endcase
    end
  end
endmodule

// File: rtl/baud_chan.sv
module baud_chan #(
  parameter int CNT_W        = 8,
  parameter int PRE_LOG2     = 4,
  parameter int FRAC_W       = 4,
  parameter bit ZERO_ILLEGAL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);
  localparam int PER_W = CNT_W + PRE_LOG2 + 1;

  logic [PER_W-1:0]  base_w, last_w, cnt_q;
  logic [FRAC_W-1:0] acc_q, acc_sum;
  logic              carry, run_w;

  assign base_w = (PER_W'(cnt_i) + PER_W'(1)) << PRE_LOG2;
  assign {carry, acc_sum} = {1'b0, acc_q} + {1'b0, frac_i};
  // a carry out of the accumulator stretches this period by one clock
  assign last_w = base_w - PER_W'(1) + PER_W'(carry);
  assign run_w  = !ZERO_ILLEGAL || (cnt_i != '0);
  assign tick_o = run_w && (cnt_q == last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (restart_i || !run_w) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
      acc_q <= acc_sum;
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  // period monitor: cycles since the previous pulse
  logic [PER_W:0] gap_q, gap_len;
  logic           seen_q;
  assign gap_len = gap_q + (PER_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (restart_i || !run_w) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_len;
    end
  end

  AST_ONE_CYCLE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R6

  AST_PERIOD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && seen_q) |->
      (gap_len == {1'b0, base_w} || gap_len == {1'b0, base_w} + (PER_W+1)'(1))); // R2
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
  import baud_frac_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int UART_CNT_W    = 8,
  parameter int IR_CNT_W      = 4,
  parameter int FRAC_W        = 4,
  parameter int FRAC_LSB      = 4,
  parameter int UART_PRE_LOG2 = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              uart_tick_o,
  output logic              ir_tick_o
);
  localparam int CNT_MAX_W = (UART_CNT_W > IR_CNT_W) ? UART_CNT_W : IR_CNT_W;

  logic [UART_CNT_W-1:0] uart_cnt_w;
  logic [IR_CNT_W-1:0]   ir_cnt_w;
  logic [FRAC_W-1:0]     uart_frac_w, ir_frac_w;
  logic [CNT_MAX_W-1:0]  cnt_w  [NUM_CH];
  logic [FRAC_W-1:0]     frac_w [NUM_CH];
  logic [NUM_CH-1:0]     tick_w;

  baud_regs #(
    .DATA_W(DATA_W), .UART_CNT_W(UART_CNT_W), .IR_CNT_W(IR_CNT_W),
    .FRAC_W(FRAC_W), .FRAC_LSB(FRAC_LSB)
  ) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .uart_cnt_o(uart_cnt_w), .ir_cnt_o(ir_cnt_w),
    .uart_frac_o(uart_frac_w), .ir_frac_o(ir_frac_w)
  );

  assign cnt_w[CH_UART]  = CNT_MAX_W'(uart_cnt_w);
  assign cnt_w[CH_IR]    = CNT_MAX_W'(ir_cnt_w);
  assign frac_w[CH_UART] = uart_frac_w;
  assign frac_w[CH_IR]   = ir_frac_w;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    baud_chan #(
      .CNT_W(CNT_MAX_W),
      .PRE_LOG2((g == CH_UART) ? UART_PRE_LOG2 : 0),
      .FRAC_W(FRAC_W),
      .ZERO_ILLEGAL(g == CH_IR)
    ) i_chan (
      .clk_i, .rst_ni,
      .restart_i(wr_en_i),
      .cnt_i(cnt_w[g]),
      .frac_i(frac_w[g]),
      .tick_o(tick_w[g])
    );
  end

  assign uart_tick_o = tick_w[CH_UART];
  assign ir_tick_o   = tick_w[CH_IR];

  AST_IR_ZERO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_cnt_w == '0) |-> !ir_tick_o); // R5

  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (!uart_tick_o && !ir_tick_o)); // R7
endmodule

// File: tb/test_baud_frac_gen.sv
module test_baud_frac_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        uart_tick, ir_tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int m_cnt [2];
  int m_frac[2];
  int m_pos [2];
  int m_acc [2];

  always #2.5 clk = ~clk;

  baud_frac_gen i_baud_frac_gen (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .uart_tick_o(uart_tick), .ir_tick_o(ir_tick)
  );

  function automatic int m_base(int ch);
    return (ch == 0) ? (m_cnt[0] + 1) * 16 : m_cnt[1] + 1;
  endfunction

  function automatic bit m_run(int ch);
    return (ch == 0) || (m_cnt[1] != 0);
  endfunction

  function automatic int m_len(int ch);
    return m_base(ch) + (((m_acc[ch] + m_frac[ch]) >= 16) ? 1 : 0);
  endfunction

  function automatic bit m_tick(int ch);
    return m_run(ch) && (m_pos[ch] == m_len(ch) - 1);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_frac[c] = 0; m_pos[c] = 0; m_acc[c] = 0;
      end
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: m_cnt[0]  = int'(wr_data[7:0]);
        2'd1: m_frac[0] = int'(wr_data[7:4]);
        2'd2: m_cnt[1]  = int'(wr_data[3:0]);
        default: m_frac[1] = int'(wr_data[7:4]);
      endcase
      for (int c = 0; c < 2; c++) begin
        m_pos[c] = 0; m_acc[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (!m_run(c)) begin
          m_pos[c] = 0; m_acc[c] = 0;
        end else if (m_tick(c)) begin
          m_pos[c] = 0;
          m_acc[c] = (m_acc[c] + m_frac[c]) % 16;
        end else begin
          m_pos[c]++;
        end
      end
    end
  end

  // per-cycle comparison against the model (R2 R4 stretch order, R1 R3 divisors)
  always @(negedge clk) begin
    if (rst_ni) begin
      checks++;
      if (uart_tick !== m_tick(0)) begin
        errors++;
        $display("FAIL R2 cycle %0d uart_tick actual %0b expected %0b", cycles, uart_tick, m_tick(0));
      end
      checks++;
      if (ir_tick !== m_tick(1)) begin
        errors++;
        $display("FAIL R4 cycle %0d ir_tick actual %0b expected %0b", cycles, ir_tick, m_tick(1));
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic tick_of(int ch);
    return (ch == 0) ? uart_tick : ir_tick;
  endfunction

  // cycles spanned by 16 consecutive periods; also flags adjacent pulses (R6)
  task automatic measure(int ch, string req, int exp);
    int n = 0, t = 0, dbl = 0;
    logic prev;
    while (!tick_of(ch)) @(negedge clk);
    prev = 1'b1;
    while (t < 16) begin
      @(negedge clk);
      n++;
      if (tick_of(ch)) begin
        t++;
        if (prev) dbl++;
      end
      prev = tick_of(ch);
    end
    check(req, n, exp);
    check("R6", dbl, 0);
  endtask

  task automatic count_ticks(int ch, int len, output int cnt);
    cnt = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tick_of(ch)) cnt++;
    end
  endtask

  initial begin
    int n;
    int cnt;
    repeat (3) @(negedge clk);
    check("R9", int'(uart_tick), 0);
    check("R9", int'(ir_tick), 0);
    rst_ni = 1'b1;
    // R9: reset defaults
    measure(0, "R9", 16 * 16);
    count_ticks(1, 100, cnt);
    check("R9", cnt, 0);

    // R1 R2 R8: serial count 3, fraction 5, junk outside fields
    wr(0, 16'hAB03);
    wr(1, 16'h005F);
    measure(0, "R1", 16 * 64 + 5);
    measure(0, "R2", 16 * 64 + 5);

    // R3 R4 R8: infrared count 7, fraction 15
    wr(2, 16'h00F7);
    wr(3, 16'hFFF3);
    measure(1, "R3", 16 * 8 + 15);
    measure(1, "R4", 16 * 8 + 15);

    // R6: shortest infrared divisor with maximum fraction
    wr(2, 16'h0001);
    measure(1, "R6", 16 * 2 + 15);
    wr(3, 16'h0000);
    measure(1, "R3", 16 * 2);

    // R5: zero infrared count silences the channel
    wr(2, 16'hFFF0);
    count_ticks(1, 300, cnt);
    check("R5", cnt, 0);

    // R7: mid-period write restarts the phase
    wr(0, 16'h0000);
    wr(1, 16'h0090);
    repeat (7) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0004;
    @(negedge clk);
    wr_en = 1'b0;
    n = 1;
    check("R7", int'(uart_tick), 0);
    check("R7", int'(ir_tick), 0);
    while (!uart_tick && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R7", n, 16);
    measure(0, "R2", 16 * 16 + 9);
    measure(1, "R3", 16 * 5);

    repeat (20) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule